// File: doc/BRIEF.md
# Semi-Parallel Successive Cancellation Decoder Scheduler

This block sequences a successive cancellation polar decoder that has N = 2^n leaf values and only P = 2^p processing elements. After a start pulse it steps through the decoding tree one cycle at a time. Each cycle it presents the bit being estimated, the tree stage being updated and the portion of that stage in flight. From these it derives the function the processing elements apply (the f/min branch or the g/sum branch), the word addresses the likelihood memory is read from and written to, and the base index of the partial-sum bits needed by g. A stage with more node updates than processing elements is split over several consecutive cycles. The datapath, memories and frozen-bit table sit outside and follow these outputs.

An optional paired mode finishes two bits per stage-0 visit: the element in stage 0 produces the f result and both candidate g results in the same cycle. Stage 0 is then visited N/2 times instead of N, which removes N/2 cycles from every codeword. The control pins are plain levels and pulses. There is no data stream, so there is no valid/ready handshake and no back-pressure. A run cannot be stalled once started.

Top module: `sc_sched`

## Requirements
- R1: Out of reset and while idle: busy=0, done=0, bit_idx=0, stage=n-1, portion=0.
- R2: A start pulse while idle makes busy=1 from the next cycle, with bit_idx=0, stage=n-1 and portion=0. A start pulse while busy has no effect on the sequence or on its length.
- R3: A visit to stage l lasts max(1, 2^(l-p)) consecutive cycles, with portion counting 0,1,2,… and returning to 0 when the visit ends.
- R4: After a visit to stage l>0 ends, the next cycle is at stage l-1 with the same bit_idx. After a stage-0 visit ends, bit_idx advances by the step, and stage becomes the index of the lowest set bit of the new bit_idx.
- R5: With PAIR_EN=1 the step is 2, bit_idx stays even, and pair_stage0 is 1 exactly in busy stage-0 cycles. With PAIR_EN=0 the step is 1 and pair_stage0 stays 0.
- R6: fg_sel equals bit `stage` of bit_idx, where 1 selects g and 0 selects f.
- R7: With words of P values and base(l) = sum over k<l of max(1, 2^(k-p)), llr_wr_addr = base(stage)+portion and llr_rd_addr = base(stage+1)+2·portion. The channel values start at base(n).
- R8: psum_idx = 2^stage − 1 + portion·P.
- R9: A run lasts sum over l of 2^(n-l)·max(1, 2^(l-p)) busy cycles, minus N/2 in paired mode. For n=4, p=1 this is 40 cycles unpaired and 32 cycles paired, and the unpaired count is never below 2N−2.
- R10: done is high for exactly one cycle: the first cycle after the last busy cycle, in which busy is already 0 and the R1 idle values are shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one codeword; ignored while busy |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle pulse after the final cycle |
| bit_idx | output | N_LOG2 | Current bit index |
| stage | output | STG_W | Current tree stage (0 is the leaf stage) |
| portion | output | PS_W | Slice of a wide stage handled this cycle |
| fg_sel | output | 1 | 1: g update, 0: f update |
| pair_stage0 | output | 1 | Stage-0 cycle that resolves two bits |
| llr_rd_addr | output | AW | First of two read words (P values each) |
| llr_wr_addr | output | AW | Write word for this cycle's results |
| psum_idx | output | N_LOG2 | First partial-sum bit used by this cycle |

## Verification
The properties assume that start is a single-cycle level sampled at the clock and that reset is held for at least one edge before the first start. The stage, bit and done rules are only judged while a run is in progress or right after one ends. The stimulus drives start for exactly one cycle between clock edges. It also issues one start in the middle of a run, so the assumption that only an idle start matters is exercised rather than avoided. The sequence is compared against a model built from the stage and portion rules for both the paired and the unpaired build.

// File: rtl/scsched_pkg.sv
package scsched_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

  // Words of P values occupied by the results of stage l.
  function automatic int unsigned blk_words(int unsigned l, int unsigned p);
    return (l > p) ? (32'd1 << (l - p)) : 32'd1;
  endfunction

  // First word of the region holding stage l results.
  function automatic int unsigned llr_base(int unsigned l, int unsigned p);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < l; k++) acc += blk_words(k, p);
    return acc;
  endfunction

endpackage

// File: rtl/sc_lowbit.sv
module sc_lowbit #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] pos
);
  // Index of the lowest set bit; an all-zero vector maps to W-1.
  always_comb begin
    pos = IW'(W - 1);
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) pos = IW'(k);
    end
  end
endmodule

// File: rtl/sc_portion_ctr.sv
module sc_portion_ctr #(
  parameter int N_LOG2 = 4,
  parameter int P_LOG2 = 1,
  parameter int STG_W  = 2,
  parameter int PS_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [STG_W-1:0] stage,
  output logic [PS_W-1:0]  portion,
  output logic             last
);
  logic [PS_W-1:0] lim;

  always_comb begin
    if (int'(stage) > P_LOG2) lim = PS_W'((1 << (int'(stage) - P_LOG2)) - 1);
    else                      lim = '0;
  end

  assign last = run && (portion == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)              portion <= '0;
    else if (!run || last)   portion <= '0;
    else                     portion <= portion + 1'b1;
  end
endmodule

// File: rtl/sc_addr_gen.sv
module sc_addr_gen
  import scsched_pkg::*;
#(
  parameter int N_LOG2 = 4,
  parameter int P_LOG2 = 1,
  parameter int STG_W  = 2,
  parameter int PS_W   = 2,
  parameter int AW     = 4
) (
  input  logic [STG_W-1:0]  stage,
  input  logic [PS_W-1:0]   portion,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     wr_addr,
  output logic [N_LOG2-1:0] psum_idx
);
  logic [AW-1:0]     base_tab [N_LOG2+1];
  logic [STG_W:0]    src_stg;
  logic [N_LOG2-1:0] stage_pow;

  for (genvar g = 0; g <= N_LOG2; g++) begin : g_base
    assign base_tab[g] = AW'(llr_base(g, P_LOG2));
  end

  always_comb begin
    src_stg   = {1'b0, stage} + 1'b1;
    wr_addr   = base_tab[stage] + AW'(portion);
    rd_addr   = base_tab[src_stg] + (AW'(portion) << 1);
    stage_pow = N_LOG2'(1) << stage;
    psum_idx  = stage_pow - 1'b1 + (N_LOG2'(portion) << P_LOG2);
  end
endmodule

// File: rtl/sc_sched.sv
module sc_sched
  import scsched_pkg::*;
#(
  parameter int N_LOG2  = 4,
  parameter int P_LOG2  = 1,
  parameter bit PAIR_EN = 1'b1,
  localparam int STG_W  = (N_LOG2 > 1) ? $clog2(N_LOG2) : 1,
  localparam int PS_W   = (N_LOG2 - 1 - P_LOG2 > 0) ? (N_LOG2 - 1 - P_LOG2) : 1,
  localparam int AW     = $clog2(llr_base(N_LOG2 + 1, P_LOG2))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [N_LOG2-1:0] bit_idx,
  output logic [STG_W-1:0]  stage,
  output logic [PS_W-1:0]   portion,
  output logic              fg_sel,
  output logic              pair_stage0,
  output logic [AW-1:0]     llr_rd_addr,
  output logic [AW-1:0]     llr_wr_addr,
  output logic [N_LOG2-1:0] psum_idx
);
  localparam int STEP = PAIR_EN ? 2 : 1;

  run_state_e        state_q;
  logic [N_LOG2-1:0] bit_q;
  logic [STG_W-1:0]  stg_q;
  logic              done_q;
  logic [N_LOG2:0]   i_inc;
  logic [N_LOG2-1:0] i_next;
  logic              wrap;
  logic [STG_W-1:0]  low_pos;
  logic              stage_end;
  logic              run;

  assign run    = (state_q == ST_RUN);
  assign i_inc  = {1'b0, bit_q} + (N_LOG2 + 1)'(STEP);
  assign i_next = i_inc[N_LOG2-1:0];
  assign wrap   = i_inc[N_LOG2];

  sc_lowbit #(.W(N_LOG2), .IW(STG_W)) u_low (
    .vec (i_next),
    .pos (low_pos)
  );

  sc_portion_ctr #(.N_LOG2(N_LOG2), .P_LOG2(P_LOG2), .STG_W(STG_W), .PS_W(PS_W)) u_portion (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .stage   (stg_q),
    .portion (portion),
    .last    (stage_end)
  );

  sc_addr_gen #(.N_LOG2(N_LOG2), .P_LOG2(P_LOG2), .STG_W(STG_W), .PS_W(PS_W), .AW(AW)) u_addr (
    .stage    (stg_q),
    .portion  (portion),
    .rd_addr  (llr_rd_addr),
    .wr_addr  (llr_wr_addr),
    .psum_idx (psum_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      stg_q   <= STG_W'(N_LOG2 - 1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            bit_q   <= '0;
            stg_q   <= STG_W'(N_LOG2 - 1);
          end
        end
        ST_RUN: begin
          if (stage_end) begin
            if (stg_q != '0) begin
              stg_q <= stg_q - 1'b1;
            end else if (wrap) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              bit_q   <= '0;
              stg_q   <= STG_W'(N_LOG2 - 1);
            end else begin
              bit_q <= i_next;
              stg_q <= low_pos;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = run;
  assign done        = done_q;
  assign bit_idx     = bit_q;
  assign stage       = stg_q;
  assign fg_sel      = bit_q[stg_q];
  assign pair_stage0 = PAIR_EN && run && (stg_q == '0);
endmodule

// File: rtl/sc_sched_chk.sv
module sc_sched_chk
  import scsched_pkg::*;
#(
  parameter int N_LOG2  = 4,
  parameter int P_LOG2  = 1,
  parameter bit PAIR_EN = 1'b1,
  localparam int STG_W  = (N_LOG2 > 1) ? $clog2(N_LOG2) : 1,
  localparam int PS_W   = (N_LOG2 - 1 - P_LOG2 > 0) ? (N_LOG2 - 1 - P_LOG2) : 1,
  localparam int AW     = $clog2(llr_base(N_LOG2 + 1, P_LOG2))
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [N_LOG2-1:0] bit_idx,
  input logic [STG_W-1:0]  stage,
  input logic [PS_W-1:0]   portion,
  input logic              fg_sel,
  input logic              pair_stage0,
  input logic [AW-1:0]     llr_rd_addr,
  input logic [AW-1:0]     llr_wr_addr,
  input logic [N_LOG2-1:0] psum_idx
);
  localparam int STEP = PAIR_EN ? 2 : 1;

  AST_PORTION_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(portion) < ((int'(stage) > P_LOG2) ? (1 << (int'(stage) - P_LOG2)) : 1))); // R3

  AST_STAGE_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(stage) != '0 && stage != $past(stage))
      |-> (stage == $past(stage) - 1'b1)); // R4

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && bit_idx != $past(bit_idx))
      |-> (int'(bit_idx) == int'($past(bit_idx)) + STEP && $past(stage) == '0)); // R4

  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && PAIR_EN) |-> !bit_idx[0]); // R5

  AST_PAIR_ONLY_S0: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stage0 |-> (busy && stage == '0 && !fg_sel)); // R5

  AST_WR_BELOW_RD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (llr_wr_addr < llr_rd_addr)); // R7

  AST_PSUM_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stage == '0) |-> (psum_idx == '0)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !$past(start && !busy))); // R10
endmodule

bind sc_sched sc_sched_chk #(.N_LOG2(N_LOG2), .P_LOG2(P_LOG2), .PAIR_EN(PAIR_EN)) u_chk (.*);

// File: tb/sc_sched_tb.sv
module sc_sched_tb;
  localparam int NL = 4;
  localparam int PL = 1;
  localparam int NN = 1 << NL;
  localparam int PP = 1 << PL;

  // columns: bit, stage, portion, fg, rd, wr, psum, pair  (paired build, first 12 cycles)
  localparam int TBL [12][8] = '{
    '{0,3,0,0, 8,4, 7,0}, '{0,3,1,0,10,5, 9,0}, '{0,3,2,0,12,6,11,0},
    '{0,3,3,0,14,7,13,0}, '{0,2,0,0, 4,2, 3,0}, '{0,2,1,0, 6,3, 5,0},
    '{0,1,0,0, 2,1, 1,0}, '{0,0,0,0, 1,0, 0,1}, '{2,1,0,1, 2,1, 1,0},
    '{2,0,0,0, 1,0, 0,1}, '{4,2,0,1, 4,2, 3,0}, '{4,2,1,1, 6,3, 5,0}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_p = 1'b0, start_s = 1'b0;
  always #4 clk = ~clk;

  logic       busy_p, done_p, fg_p, pr_p, busy_s, done_s, fg_s, pr_s;
  logic [3:0] bit_p, bit_s, rd_p, rd_s, wr_p, wr_s, ps_p, ps_s;
  logic [1:0] stg_p, stg_s, por_p, por_s;

  sc_sched #(.N_LOG2(NL), .P_LOG2(PL), .PAIR_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_p), .busy(busy_p), .done(done_p),
    .bit_idx(bit_p), .stage(stg_p), .portion(por_p), .fg_sel(fg_p), .pair_stage0(pr_p),
    .llr_rd_addr(rd_p), .llr_wr_addr(wr_p), .psum_idx(ps_p));

  sc_sched #(.N_LOG2(NL), .P_LOG2(PL), .PAIR_EN(1'b0)) u_dut_seq (
    .clk(clk), .rst_n(rst_n), .start(start_s), .busy(busy_s), .done(done_s),
    .bit_idx(bit_s), .stage(stg_s), .portion(por_s), .fg_sel(fg_s), .pair_stage0(pr_s),
    .llr_rd_addr(rd_s), .llr_wr_addr(wr_s), .psum_idx(ps_s));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cnt_of(input int l);
    return (l > PL) ? (1 << (l - PL)) : 1;
  endfunction
  function automatic int base_of(input int l);
    int acc = 0;
    for (int k = 0; k < l; k++) acc += cnt_of(k);
    return acc;
  endfunction
  function automatic int low_of(input int v);
    for (int k = 0; k < NL; k++) if (v[k]) return k;
    return NL - 1;
  endfunction

  // Pick the outputs of one build; paired=1 selects u_dut.
  task automatic sample(input bit paired, output int o[11]);
    o[0] = paired ? busy_p : busy_s;   o[1] = paired ? done_p : done_s;
    o[2] = paired ? bit_p : bit_s;     o[3] = paired ? stg_p : stg_s;
    o[4] = paired ? por_p : por_s;     o[5] = paired ? fg_p : fg_s;
    o[6] = paired ? rd_p : rd_s;       o[7] = paired ? wr_p : wr_s;
    o[8] = paired ? ps_p : ps_s;       o[9] = paired ? pr_p : pr_s;
    o[10] = 0;
  endtask

  task automatic pulse_start(input bit paired);
    if (paired) start_p = 1'b1; else start_s = 1'b1;
    @(negedge clk);
    start_p = 1'b0; start_s = 1'b0;
  endtask

  // Full model comparison of one run; inj>=0 pulses start at that busy cycle.
  task automatic model_run(input bit paired, input int inj);
    int o[11];
    int mi = 0, ml = NL - 1, mps = 0, cyc = 0, exp_cyc = 0, step;
    bit end_run = 1'b0, bad;
    step = paired ? 2 : 1;
    for (int l = 0; l < NL; l++) exp_cyc += (1 << (NL - l)) * cnt_of(l);
    if (paired) exp_cyc -= NN / 2;
    pulse_start(paired);
    while (!end_run && cyc < 1000) begin
      sample(paired, o);
      bad = (o[0] != 1) || (o[2] != mi) || (o[3] != ml) || (o[4] != mps) ||
            (o[5] != ((mi >> ml) & 1)) || (o[6] != base_of(ml + 1) + 2 * mps) ||
            (o[7] != base_of(ml) + mps) || (o[8] != (1 << ml) - 1 + mps * PP) ||
            (o[9] != ((paired && ml == 0) ? 1 : 0)) || (o[1] != 0);
      // R3 R4 R5 R6 R7 R8: one cycle of the schedule
      chk("R4 schedule (i,l,ps,fg,addr,psum,pair) mismatch flag", int'(bad), 0);
      if (bad) $display("  cycle %0d: i=%0d l=%0d ps=%0d  expected i=%0d l=%0d ps=%0d",
                        cyc, o[2], o[3], o[4], mi, ml, mps);
      cyc++;
      if (mps < cnt_of(ml) - 1) mps++;
      else begin
        mps = 0;
        if (ml > 0) ml--;
        else begin
          mi += step;
          if (mi >= NN) end_run = 1'b1; else ml = low_of(mi);
        end
      end
      if (cyc - 1 == inj) begin
        if (paired) start_p = 1'b1; else start_s = 1'b1;
        @(negedge clk);
        start_p = 1'b0; start_s = 1'b0;
      end else @(negedge clk);
    end
    chk(paired ? "R9 paired cycle count" : "R9 unpaired cycle count", cyc, exp_cyc);
    if (!paired) chk("R9 unpaired at least 2N-2", int'(cyc >= 2 * NN - 2), 1);
    sample(paired, o);
    chk("R10 done high after last cycle", o[1], 1);
    chk("R10 busy low with done", o[0], 0);
    chk("R10 idle stage shown with done", o[3], NL - 1);
    @(negedge clk);
    sample(paired, o);
    chk("R10 done is one cycle", o[1], 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int o[11];
    repeat (3) @(negedge clk);
    // R1: reset state
    sample(1'b1, o);
    chk("R1 busy in reset", o[0], 0);
    chk("R1 done in reset", o[1], 0);
    rst_n = 1'b1;
    @(negedge clk);
    sample(1'b1, o);
    chk("R1 idle bit", o[2], 0);
    chk("R1 idle stage", o[3], NL - 1);
    chk("R1 idle portion", o[4], 0);
    repeat (3) @(negedge clk);
    sample(1'b0, o);
    chk("R2 stays idle without start", o[0], 0);

    // Table walk: paired build, first twelve cycles
    pulse_start(1'b1);
    for (int k = 0; k < 12; k++) begin
      sample(1'b1, o);
      chk("R2 busy", o[0], 1);
      chk("R4 bit index", o[2], TBL[k][0]);
      chk("R4 stage", o[3], TBL[k][1]);
      chk("R3 portion", o[4], TBL[k][2]);
      chk("R6 f/g select", o[5], TBL[k][3]);
      chk("R7 read word", o[6], TBL[k][4]);
      chk("R7 write word", o[7], TBL[k][5]);
      chk("R8 partial-sum index", o[8], TBL[k][6]);
      chk("R5 pair flag", o[9], TBL[k][7]);
      @(negedge clk);
    end
    while (busy_p) @(negedge clk);
    @(negedge clk);

    // Full runs against the model
    model_run(1'b1, -1);
    model_run(1'b0, -1);
    sample(1'b0, o);
    chk("R5 unpaired never flags pairing", o[9], 0);
    // R2: start while busy must not disturb the schedule or its length
    model_run(1'b1, 5);
    model_run(1'b0, 17);
    // back-to-back restart right after done
    model_run(1'b1, -1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule